// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes handed over by a host into asynchronous serial frames on a single line. It has two storage stages: a holding register that the host fills and a frame shift register that drives the line. To hand a byte over, the host writes the holding register and then clears the empty flag. The block sees the cleared flag and moves the byte into the shift register. It sets the flag again at once, so the host can write the next byte while the current frame is still on the line. Bytes written this way leave the line back to back, with no idle gap between frames.

Each frame starts with a low start bit. The data bits follow, least significant first. Next comes an optional extra bit, which is even parity, odd parity or a host-supplied multiprocessor marker. One or two high stop bits end the frame. The bit rate is set by a baud tick enable from outside the block, and each bit lasts a fixed number of tick pulses. When the block is enabled, it first sends one frame time of idle 1s. An end flag tells the host when the line has gone quiet. While the transmitter is disabled, a break control can pull the line low.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, txd is 1, txEmpty is 1, txEnd is 1 and txIrq is 0.
- R2: When txEnable goes high, txd stays 1 for one full frame time of the current format before the first start bit. This holds even if data is already pending.
- R3: A frame is a start bit of 0, then the data bits LSB first, then the optional extra bit, then the stop bits of 1. Each bit lasts OVS (default 16) baudTick pulses.
- R4: A clrEmpty pulse drives txEmpty to 0. The byte moves to the shift register only while txEmpty is 0 and txEnable is 1, and only when the line is idle or the last stop bit is ending. In the cycle after the move, txEmpty reads 1 while the frame is still being sent.
- R5: txIrq is a one-cycle pulse that follows each move into the shift register, but only when irqEnable is 1. It stays 0 at every other time.
- R6: With fmtLen7 = 1 the frame carries data bits 6:0 only. With fmtLen7 = 0 it carries bits 7:0.
- R7: fmtParity selects the extra bit. 00 means no extra bit. 01 means even parity, so the data bits plus this bit hold an even number of ones. 10 means odd parity. 11 means the bit carries the value of mpBit.
- R8: fmtTwoStop = 1 gives two stop bits and fmtTwoStop = 0 gives one.
- R9: A move into the shift register clears txEnd. txEnd goes to 1 when the last stop bit ends and no new byte is pending. It is 1 in every cycle after one in which txEnable is 0. Back-to-back frames leave no gap and keep txEnd at 0.
- R10: The format inputs are sampled when a frame starts. Changing them during a frame does not alter that frame's bits or its length.
- R11: While txEnable is 0, txd equals the inverse of breakEnable. While txEnable is 1, breakEnable has no effect.
- R12: While enabled with nothing to send, and at all times while disabled without a break, txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmitter enable |
| baudTick | input | 1 | One-cycle baud tick enable, OVS per bit |
| wrStrobe | input | 1 | Write wrData into the holding register |
| wrData | input | DATA_W | Byte to transmit |
| clrEmpty | input | 1 | Clear the empty flag: holding register has new data |
| irqEnable | input | 1 | Enable the empty interrupt request |
| fmtLen7 | input | 1 | 1 for seven data bits, 0 for eight |
| fmtParity | input | 2 | Extra bit: 00 none, 01 even, 10 odd, 11 multiprocessor |
| fmtTwoStop | input | 1 | 1 for two stop bits |
| mpBit | input | 1 | Value of the multiprocessor bit |
| breakEnable | input | 1 | Hold the line low while disabled |
| txd | output | 1 | Serial line |
| txEmpty | output | 1 | Holding register free for new data |
| txEnd | output | 1 | Line idle, last frame fully sent |
| txIrq | output | 1 | Empty interrupt request pulse |

## Verification
A bad bit counter or a frame length latched at the wrong moment shows on txd within one bit time. Either a start bit comes one slot early or late, or txEnd rises in the middle of a stop bit instead of after it. A wrong flag handshake shows on the flags within a cycle or two of the move. The symptom is txEmpty staying 0, txIrq lasting two cycles, or a gap appearing between back-to-back frames. A bad parity or length mux corrupts a single bit slot of the first frame that uses it.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PRE  = 2'd1,
    ST_IDLE = 2'd2,
    ST_SEND = 2'd3
  } txState_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_MPB  = 2'd3
  } parMode_e;

  typedef struct packed {
    logic loadData;
    logic loadOnes;
    logic shiftBit;
  } txStrobe_t;

endpackage

// File: rtl/dbtx_ctrl.sv
module dbtx_ctrl
  import dbtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       baudTick,
  input  logic       clrEmpty,
  input  logic       irqEnable,
  input  logic       fmtLen7,
  input  logic [1:0] fmtParity,
  input  logic       fmtTwoStop,
  output txStrobe_t  strobe,
  output logic       busy,
  output logic       txEmpty,
  output logic       txEnd,
  output logic       txIrq
);

  localparam int TICK_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W  = $clog2(FRAME_W + 1);

  txState_e          state, nextState;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitsLeft;
  logic [BIT_W-1:0]  lenNow;
  logic              emptyQ, endQ, irqQ;
  logic              bitDone, lastBit;

  // frame length of the format presented right now: start + data + extra + stops
  always_comb begin
    lenNow = BIT_W'(DATA_W + 2) - BIT_W'(fmtLen7)
           + BIT_W'(fmtParity != PAR_NONE) + BIT_W'(fmtTwoStop);
  end

  assign busy    = (state == ST_PRE) || (state == ST_SEND);
  assign bitDone = busy && baudTick && (tickCnt == TICK_W'(OVS - 1));
  assign lastBit = bitDone && (bitsLeft == BIT_W'(1));

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (!txEnable) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          strobe.loadOnes = 1'b1;
          nextState       = ST_PRE;
        end
        ST_PRE, ST_SEND: begin
          if (lastBit) begin
            if (!emptyQ) begin
              strobe.loadData = 1'b1;
              nextState       = ST_SEND;
            end else begin
              nextState = ST_IDLE;
            end
          end else if (bitDone) begin
            strobe.shiftBit = 1'b1;
          end
        end
        ST_IDLE: begin
          if (!emptyQ) begin
            strobe.loadData = 1'b1;
            nextState       = ST_SEND;
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      tickCnt  <= '0;
      bitsLeft <= '0;
      emptyQ   <= 1'b1;
      endQ     <= 1'b1;
      irqQ     <= 1'b0;
    end else begin
      state <= nextState;

      if (strobe.loadData || strobe.loadOnes) begin
        tickCnt  <= '0;
        bitsLeft <= lenNow;
      end else if (busy && baudTick) begin
        tickCnt <= bitDone ? '0 : tickCnt + TICK_W'(1);
        if (bitDone) bitsLeft <= bitsLeft - BIT_W'(1);
      end

      if (strobe.loadData)  emptyQ <= 1'b1;
      else if (clrEmpty)    emptyQ <= 1'b0;

      if (!txEnable)                                  endQ <= 1'b1;
      else if (strobe.loadData)                       endQ <= 1'b0;
      else if (lastBit && state == ST_SEND && emptyQ) endQ <= 1'b1;

      irqQ <= strobe.loadData && irqEnable;
    end
  end

  assign txEmpty = emptyQ;
  assign txEnd   = endQ;
  assign txIrq   = irqQ;

endmodule

// File: rtl/dbtx_datapath.sv
module dbtx_datapath
  import dbtx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              busy,
  input  logic              txEnable,
  input  logic              breakEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fmtLen7,
  input  logic [1:0]        fmtParity,
  input  logic              mpBit,
  output logic              txd
);

  logic [DATA_W-1:0]  holdReg;
  logic [DATA_W-1:0]  dataMask;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] nextFrame;
  logic               extraBit;
  int                 dataLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         holdReg <= '0;
    else if (wrStrobe) holdReg <= wrData;
  end

  always_comb begin
    dataLen = fmtLen7 ? DATA_W - 1 : DATA_W;
    for (int i = 0; i < DATA_W; i++) dataMask[i] = (i < dataLen);
    unique case (fmtParity)
      PAR_EVEN: extraBit = ^(holdReg & dataMask);
      PAR_ODD:  extraBit = ~^(holdReg & dataMask);
      PAR_MPB:  extraBit = mpBit;
      default:  extraBit = 1'b1;
    endcase
  end

  // assemble the whole frame at once; unused upper slots stay 1 (stop / idle)
  always_comb begin
    nextFrame    = '1;
    nextFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dataLen) nextFrame[i+1] = holdReg[i];
    end
    for (int i = 1; i < FRAME_W; i++) begin
      if (fmtParity != PAR_NONE && i == dataLen + 1) nextFrame[i] = extraBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '1;
    else if (strobe.loadOnes)  shiftReg <= '1;
    else if (strobe.loadData)  shiftReg <= nextFrame;
    else if (strobe.shiftBit)  shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  always_comb begin
    if (!txEnable)  txd = ~breakEnable;
    else if (busy)  txd = shiftReg[0];
    else            txd = 1'b1;
  end

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              baudTick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrEmpty,
  input  logic              irqEnable,
  input  logic              fmtLen7,
  input  logic [1:0]        fmtParity,
  input  logic              fmtTwoStop,
  input  logic              mpBit,
  input  logic              breakEnable,
  output logic              txd,
  output logic              txEmpty,
  output logic              txEnd,
  output logic              txIrq
);

  localparam int FRAME_W = DATA_W + 4;

  txStrobe_t strobe;
  logic      busy;

  dbtx_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .FRAME_W(FRAME_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .baudTick   (baudTick),
    .clrEmpty   (clrEmpty),
    .irqEnable  (irqEnable),
    .fmtLen7    (fmtLen7),
    .fmtParity  (fmtParity),
    .fmtTwoStop (fmtTwoStop),
    .strobe     (strobe),
    .busy       (busy),
    .txEmpty    (txEmpty),
    .txEnd      (txEnd),
    .txIrq      (txIrq)
  );

  dbtx_datapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busy        (busy),
    .txEnable    (txEnable),
    .breakEnable (breakEnable),
    .wrStrobe    (wrStrobe),
    .wrData      (wrData),
    .fmtLen7     (fmtLen7),
    .fmtParity   (fmtParity),
    .mpBit       (mpBit),
    .txd         (txd)
  );

endmodule

// File: rtl/dbuf_serial_tx_checker.sv
module dbuf_serial_tx_checker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic breakEnable,
  input logic irqEnable,
  input logic txd,
  input logic txEmpty,
  input logic txEnd,
  input logic txIrq
);

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(irqEnable));

  assert_irq_with_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (txEmpty && !txEnd));

  assert_empty_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> !txEnd);

  assert_end_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> txEnd);

  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && breakEnable) |-> !txd);

  assert_idle_high_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && txEnd) |-> txd);

endmodule

bind dbuf_serial_tx dbuf_serial_tx_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txEnable    (txEnable),
  .breakEnable (breakEnable),
  .irqEnable   (irqEnable),
  .txd         (txd),
  .txEmpty     (txEmpty),
  .txEnd       (txEnd),
  .txIrq       (txIrq)
);

// File: tb/dbuf_serial_tx_bench.sv
module dbuf_serial_tx_bench;

  localparam int BIT_CYC = 32;   // OVS=16 ticks, one tick every 2 cycles

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       clrEmpty = 1'b0;
  logic       irqEnable = 1'b0;
  logic       fmtLen7 = 1'b0;
  logic [1:0] fmtParity = 2'b00;
  logic       fmtTwoStop = 1'b0;
  logic       mpBit = 1'b0;
  logic       breakEnable = 1'b0;
  logic       txd, txEmpty, txEnd, txIrq;

  int nChecks = 0;
  int nFails = 0;
  int irqCount = 0;
  bit done = 1'b0;

  dbuf_serial_tx u_dbuf_serial_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .wrStrobe(wrStrobe), .wrData(wrData), .clrEmpty(clrEmpty),
    .irqEnable(irqEnable), .fmtLen7(fmtLen7), .fmtParity(fmtParity),
    .fmtTwoStop(fmtTwoStop), .mpBit(mpBit), .breakEnable(breakEnable),
    .txd(txd), .txEmpty(txEmpty), .txEnd(txEnd), .txIrq(txIrq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) baudTick <= 1'b0;
    else       baudTick <= ~baudTick;
  end

  always @(negedge clk) if (rstN && txIrq) irqCount++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic buildFrame(input logic [7:0] d, input bit len7, input logic [1:0] par,
                            input bit mp, input bit two,
                            output logic [11:0] bits, output int n);
    int dl;
    logic p;
    bits = '1;
    n = 0;
    bits[n] = 1'b0; n++;
    dl = len7 ? 7 : 8;
    p = 1'b0;
    for (int i = 0; i < dl; i++) begin
      bits[n] = d[i]; n++;
      p = p ^ d[i];
    end
    if (par == 2'b01)      begin bits[n] = p;  n++; end
    else if (par == 2'b10) begin bits[n] = ~p; n++; end
    else if (par == 2'b11) begin bits[n] = mp; n++; end
    bits[n] = 1'b1; n++;
    if (two) begin bits[n] = 1'b1; n++; end
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); wrData = d; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0; clrEmpty = 1'b1;
    @(negedge clk); clrEmpty = 1'b0;
  endtask

  task automatic waitStart(input string req);
    int guard = 0;
    while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    check(guard < 2000, req, guard, 0);
  endtask

  // synced=1: already at mid start bit. Leaves the caller at mid of the slot after the frame.
  task automatic expectFrame(input logic [11:0] bits, input int n, input bit synced,
                             input bit isLast, input string req);
    if (!synced) begin
      waitStart(req);
      repeat (BIT_CYC/2) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      check(txd === bits[i], req, txd, bits[i]);
      check(txEnd === 1'b0, "R9 busy", txEnd, 0);
      repeat (BIT_CYC) @(negedge clk);
    end
    if (isLast) begin
      check(txEnd === 1'b1, "R9 end after last stop", txEnd, 1);
      check(txd === 1'b1, "R12 idle high", txd, 1);
    end
  endtask

  task automatic waitEnd();
    int guard = 0;
    while (txEnd !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    check(guard < 2000, "R9 wait end", guard, 0);
  endtask

  task automatic testReset();
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(txEmpty === 1'b1, "R1 txEmpty", txEmpty, 1);
    check(txEnd === 1'b1, "R1 txEnd", txEnd, 1);
    check(txIrq === 1'b0, "R1 txIrq", txIrq, 0);
  endtask

  task automatic testPreamble();
    logic [11:0] bits; int n; int cyc; int irq0;
    fmtLen7 = 1'b0; fmtParity = 2'b00; fmtTwoStop = 1'b0; irqEnable = 1'b1;
    sendByte(8'hA5);
    repeat (40) @(negedge clk);
    check(txEmpty === 1'b0, "R4 empty cleared", txEmpty, 0);
    check(txd === 1'b1, "R12 disabled idle", txd, 1);
    irq0 = irqCount;
    txEnable = 1'b1;
    cyc = 0;
    while (txd === 1'b1 && cyc < 2000) begin @(negedge clk); cyc++; end
    check(cyc >= 10*BIT_CYC - 3 && cyc <= 10*BIT_CYC + 3, "R2 preamble length", cyc, 10*BIT_CYC);
    check(txEmpty === 1'b1, "R4 empty set on load", txEmpty, 1);
    @(negedge clk);
    check(irqCount == irq0 + 1, "R5 irq once", irqCount, irq0 + 1);
    buildFrame(8'hA5, 1'b0, 2'b00, 1'b0, 1'b0, bits, n);
    expectFrame(bits, n, 1'b0, 1'b1, "R3 frame 8N1");
  endtask

  task automatic oneFormat(input logic [7:0] d, input bit len7, input logic [1:0] par,
                           input bit mp, input bit two, input bit irqEn, input string req);
    logic [11:0] bits; int n; int irq0;
    waitEnd();
    fmtLen7 = len7; fmtParity = par; mpBit = mp; fmtTwoStop = two; irqEnable = irqEn;
    irq0 = irqCount;
    buildFrame(d, len7, par, mp, two, bits, n);
    sendByte(d);
    expectFrame(bits, n, 1'b0, 1'b1, req);
    check(irqCount == irq0 + (irqEn ? 1 : 0), "R5 irq count", irqCount, irq0 + (irqEn ? 1 : 0));
  endtask

  task automatic testFormats();
    oneFormat(8'h53, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, "R6 R7 R8 7E2");
    oneFormat(8'h0F, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7 8O1");
    oneFormat(8'h3C, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1, "R7 multiproc 1");
    oneFormat(8'hFF, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, "R6 R7 multiproc 0");
    oneFormat(8'h81, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, "R7 R8 8E2");
  endtask

  task automatic testBackToBack();
    logic [11:0] b1, b2; int n1, n2; int guard;
    waitEnd();
    fmtLen7 = 1'b0; fmtParity = 2'b00; fmtTwoStop = 1'b0;
    buildFrame(8'h5A, 1'b0, 2'b00, 1'b0, 1'b0, b1, n1);
    buildFrame(8'hC6, 1'b0, 2'b00, 1'b0, 1'b0, b2, n2);
    sendByte(8'h5A);
    guard = 0;
    while (txEmpty !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    check(guard < 200, "R4 reload free", guard, 0);
    sendByte(8'hC6);
    check(txEmpty === 1'b0, "R4 second pending", txEmpty, 0);
    expectFrame(b1, n1, 1'b0, 1'b0, "R9 first of pair");
    check(txd === 1'b0, "R9 no gap start", txd, 0);
    check(txEmpty === 1'b1, "R4 second loaded", txEmpty, 1);
    expectFrame(b2, n2, 1'b1, 1'b1, "R9 second of pair");
  endtask

  task automatic testMidChange();
    logic [11:0] bits; int n; int guard;
    waitEnd();
    fmtLen7 = 1'b0; fmtParity = 2'b00; fmtTwoStop = 1'b0;
    buildFrame(8'hC3, 1'b0, 2'b00, 1'b0, 1'b0, bits, n);
    sendByte(8'hC3);
    guard = 0;
    while (txd !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    fmtLen7 = 1'b1; fmtParity = 2'b01; fmtTwoStop = 1'b1;
    expectFrame(bits, n, 1'b0, 1'b1, "R10 format held");
    fmtLen7 = 1'b0; fmtParity = 2'b00; fmtTwoStop = 1'b0;
  endtask

  task automatic testBreak();
    waitEnd();
    @(negedge clk); breakEnable = 1'b1;
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R11 break ignored enabled", txd, 1);
    txEnable = 1'b0;
    #1;
    check(txd === 1'b0, "R11 break low", txd, 0);
    @(negedge clk); breakEnable = 1'b0;
    #1;
    check(txd === 1'b1, "R11 break released", txd, 1);
    // abort mid-frame by disabling
    @(negedge clk); txEnable = 1'b1;
    sendByte(8'h00);
    repeat (12*BIT_CYC + 100) @(negedge clk);
    check(txEnd === 1'b0, "R9 busy before abort", txEnd, 0);
    txEnable = 1'b0;
    @(negedge clk);
    check(txEnd === 1'b1, "R9 end when disabled", txEnd, 1);
    check(txd === 1'b1, "R12 disabled high", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPreamble();
    testFormats();
    testBackToBack();
    testMidChange();
    testBreak();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule